// File: doc/BRIEF.md
# Indirect Register Access Window

This block gives a host, through a handful of directly mapped 32-bit registers, access to two internal spaces that it cannot address directly: a bank of shared registers and a word-addressed internal memory. Shared registers are reached through a command word. The host writes a control register holding a 16-bit target offset and a 2-bit operation code. A read operation fetches the target into a data register. A write operation pushes a data value, which the host loaded into that data register beforehand, out to the target.

The memory side is a streaming window. The host loads a read pointer or a write pointer, then moves data through the matching data register. Each data access advances its pointer by one 32-bit word. Loading the read pointer starts a prefetch. Each read of the read-data register returns the prefetched word and starts the fetch of the next one, so that back-to-back reads walk through consecutive words.

All internal traffic leaves on one request port with a valid/ready handshake and a separate response-valid strobe for reads. One read is in flight at most. A busy output tells the host when a launched access has not yet completed. The host waits for busy to fall before it reads a data register or starts another window access.

Top module: `indirect_reg_window`

## Requirements
- R1: After reset, busy and the request valid are low, and the control, shared-data, read-pointer, write-pointer and read-data registers all read as zero.
- R2: Writing the control register (host offset 0x0EC) with operation code 2 in bits 29:28 issues exactly one register-space read (int_req_mem=0, int_req_write=0) at the zero-extended offset from bits 15:0. The response is stored in the shared-data register (host offset 0x0F4). Busy is high from the cycle after the control write until the cycle after the response.
- R3: Writing the control register with operation code 3 issues exactly one register-space write (int_req_write=1) to the offset, carrying the value last written to the shared-data register. Busy falls in the cycle after the request is accepted.
- R4: A control write with operation code 0 or 1 issues no internal request, and busy stays low.
- R5: Writing the read pointer (host offset 0x40C) issues a memory-space read (int_req_mem=1) at that address. Once busy is low, the read-data register (host offset 0x41C) returns the word fetched, and the read pointer reads back the value loaded.
- R6: Each host read of the read-data register returns the current word, advances the read pointer by 4, and prefetches the word at the new pointer. Successive reads return successive words.
- R7: Each write to the write-data register (host offset 0x418) issues a memory-space write at the write pointer (host offset 0x410) with the written data, then advances the write pointer by 4.
- R8: While the request valid is high and ready is low, the valid stays high and the request write flag, address and data stay unchanged.
- R9: No request is presented while a read response is still outstanding.
- R10: The control register reads back the offset in bits 15:0 and the operation code in bits 29:28, with every other bit zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_rd_en | input | 1 | Host register read strobe (has side effects on the read-data register) |
| host_addr | input | 12 | Host register byte offset |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Host read data, combinational from host_addr |
| host_busy | output | 1 | A launched internal access has not completed |
| int_req_valid | output | 1 | Internal request valid |
| int_req_ready | input | 1 | Internal request accepted when high with valid |
| int_req_write | output | 1 | 1 for write, 0 for read |
| int_req_mem | output | 1 | 1 targets internal memory, 0 targets shared registers |
| int_req_addr | output | AW | Internal target address |
| int_req_wdata | output | DW | Internal write data |
| int_rsp_valid | input | 1 | Read response strobe |
| int_rsp_data | input | DW | Read response data |

## Verification
The bench attacks the pointer arithmetic of the memory window. A design that returned the word at the new pointer, or stepped by one byte instead of one word, would return a shifted sequence on back-to-back reads and would put memory writes at the wrong addresses. It loads the shared-data register before a write command and checks the value that leaves the internal port: a design that latched the control word's own bits as data would be caught. It issues no-op operation codes and flags any request that appears, and it stalls the internal port with irregular ready and response latency. A design that let a request change under back-pressure, issued while a read was outstanding, or dropped busy too early would fail the per-cycle comparison.

// File: rtl/irw_pkg.sv
// Shared constants and types for the indirect register access window.
// Assumes a 12-bit host byte-offset space and a 32-bit-or-wider data path.
package irw_pkg;
    localparam int HA_W   = 12;
    localparam int OFF_W  = 16;
    localparam int OP_LSB = 28;

    localparam logic [HA_W-1:0] OFS_SHR_CTRL  = 12'h0EC;
    localparam logic [HA_W-1:0] OFS_SHR_DATA  = 12'h0F4;
    localparam logic [HA_W-1:0] OFS_MEM_RADDR = 12'h40C;
    localparam logic [HA_W-1:0] OFS_MEM_WADDR = 12'h410;
    localparam logic [HA_W-1:0] OFS_MEM_WDAT  = 12'h418;
    localparam logic [HA_W-1:0] OFS_MEM_RDAT  = 12'h41C;

    typedef enum logic [1:0] {
        OP_IDLE0 = 2'd0,
        OP_IDLE1 = 2'd1,
        OP_READ  = 2'd2,
        OP_WRITE = 2'd3
    } win_op_e;
endpackage

// File: rtl/irw_shr_engine.sv
// Shared-register command engine: holds the control word and data word,
// launches one internal read or write per control write whose op code is
// a read or write, and captures read responses into the data word.
// Assumes the host waits for busy low before issuing the next command.
module irw_shr_engine
    import irw_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic             data_we,
    input  logic [1:0]       op_in,
    input  logic [OFF_W-1:0] off_in,
    input  logic [DW-1:0]    wdata_in,
    output logic [DW-1:0]    ctrl_word,
    output logic [DW-1:0]    data_word,
    output logic             req_valid,
    output logic             req_write,
    output logic [AW-1:0]    req_addr,
    output logic [DW-1:0]    req_wdata,
    input  logic             grant,
    input  logic             rsp_valid,
    input  logic [DW-1:0]    rsp_data,
    output logic             busy
);
    logic [OFF_W-1:0] off_q;
    win_op_e          op_q;
    logic [DW-1:0]    data_q;
    logic             pend_q;
    logic             is_wr_q;
    logic             wait_q;

    // Command state: capture control/data writes, retire grants and responses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q   <= '0;
            op_q    <= OP_IDLE0;
            data_q  <= '0;
            pend_q  <= 1'b0;
            is_wr_q <= 1'b0;
            wait_q  <= 1'b0;
        end else begin
            if (grant) begin
                pend_q <= 1'b0;
                if (!is_wr_q) wait_q <= 1'b1;
            end
            if (rsp_valid) begin
                data_q <= rsp_data;
                wait_q <= 1'b0;
            end
            if (data_we) data_q <= wdata_in;
            if (ctrl_we) begin
                off_q <= off_in;
                op_q  <= win_op_e'(op_in);
                if (op_in == OP_READ) begin
                    pend_q  <= 1'b1;
                    is_wr_q <= 1'b0;
                end else if (op_in == OP_WRITE) begin
                    pend_q  <= 1'b1;
                    is_wr_q <= 1'b1;
                end
            end
        end
    end

    // Readback of the control word: offset low, op code at its field, rest zero.
    always_comb begin
        ctrl_word = '0;
        ctrl_word[OFF_W-1:0]     = off_q;
        ctrl_word[OP_LSB +: 2]   = op_q;
    end

    // Request presentation and busy.
    always_comb begin
        data_word = data_q;
        req_valid = pend_q;
        req_write = is_wr_q;
        req_addr  = AW'(off_q);
        req_wdata = data_q;
        busy      = pend_q | wait_q;
    end

    a_r2_read_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && op_in == OP_READ) |=> (busy && req_valid && !req_write));

    a_r3_write_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && op_in == OP_WRITE) |=> (req_valid && req_write));

    a_r4_idle_op: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && !op_in[1] && !busy) |=> !busy);

    a_r3_write_retire: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && req_write && !ctrl_we) |=> !busy);
endmodule

// File: rtl/irw_mem_engine.sv
// Memory streaming window: separate read and write pointers, a one-word
// prefetch buffer behind the read-data register, and a one-entry posted
// write. Pointers step by STEP bytes per data access.
// Assumes the host waits for busy low between window accesses.
module irw_mem_engine #(
    parameter int DW   = 32,
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          raddr_we,
    input  logic          waddr_we,
    input  logic          wdat_we,
    input  logic          rdat_re,
    input  logic [DW-1:0] wdata_in,
    output logic [AW-1:0] raddr_out,
    output logic [AW-1:0] waddr_out,
    output logic [DW-1:0] rdat_out,
    output logic          req_valid,
    output logic          req_write,
    output logic [AW-1:0] req_addr,
    output logic [DW-1:0] req_wdata,
    input  logic          grant,
    input  logic          rsp_valid,
    input  logic [DW-1:0] rsp_data,
    output logic          busy
);
    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    logic [AW-1:0] raddr_q, waddr_q, wr_addr_q;
    logic [DW-1:0] pf_q, wr_data_q;
    logic          rd_pend_q, rd_wait_q, wr_pend_q;

    // Pointer, prefetch and posted-write state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raddr_q   <= '0;
            waddr_q   <= '0;
            wr_addr_q <= '0;
            pf_q      <= '0;
            wr_data_q <= '0;
            rd_pend_q <= 1'b0;
            rd_wait_q <= 1'b0;
            wr_pend_q <= 1'b0;
        end else begin
            if (grant) begin
                if (wr_pend_q) begin
                    wr_pend_q <= 1'b0;
                end else begin
                    rd_pend_q <= 1'b0;
                    rd_wait_q <= 1'b1;
                end
            end
            if (rsp_valid) begin
                pf_q      <= rsp_data;
                rd_wait_q <= 1'b0;
            end
            if (raddr_we) begin
                raddr_q   <= AW'(wdata_in);
                rd_pend_q <= 1'b1;
            end else if (rdat_re) begin
                raddr_q   <= raddr_q + STEP_V;
                rd_pend_q <= 1'b1;
            end
            if (waddr_we) begin
                waddr_q <= AW'(wdata_in);
            end else if (wdat_we) begin
                wr_pend_q <= 1'b1;
                wr_addr_q <= waddr_q;
                wr_data_q <= wdata_in;
                waddr_q   <= waddr_q + STEP_V;
            end
        end
    end

    // Request presentation: a posted write goes ahead of a pending prefetch.
    always_comb begin
        req_valid = wr_pend_q | rd_pend_q;
        req_write = wr_pend_q;
        req_addr  = wr_pend_q ? wr_addr_q : raddr_q;
        req_wdata = wr_data_q;
        raddr_out = raddr_q;
        waddr_out = waddr_q;
        rdat_out  = pf_q;
        busy      = wr_pend_q | rd_pend_q | rd_wait_q;
    end

    a_r5_prefetch_launch: assert property (@(posedge clk) disable iff (!rst_n)
        raddr_we |=> (req_valid && raddr_out == $past(AW'(wdata_in))));

    a_r6_read_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rdat_re && !raddr_we) |=> (raddr_out == $past(raddr_out) + STEP_V));

    a_r7_write_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wdat_we && !waddr_we) |=> (waddr_out == $past(waddr_out) + STEP_V && req_valid && req_write));
endmodule

// File: rtl/irw_port_arb.sv
// Merges the two engines onto the single internal port. Fixed priority to the
// shared-register engine; blocks new requests while a read is outstanding and
// routes the response to the engine that issued the read.
module irw_port_arb #(
    parameter int DW = 32,
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s_valid,
    input  logic          s_write,
    input  logic [AW-1:0] s_addr,
    input  logic [DW-1:0] s_wdata,
    input  logic          m_valid,
    input  logic          m_write,
    input  logic [AW-1:0] m_addr,
    input  logic [DW-1:0] m_wdata,
    output logic          s_grant,
    output logic          m_grant,
    output logic          s_rsp,
    output logic          m_rsp,
    output logic          int_req_valid,
    input  logic          int_req_ready,
    output logic          int_req_write,
    output logic          int_req_mem,
    output logic [AW-1:0] int_req_addr,
    output logic [DW-1:0] int_req_wdata,
    input  logic          int_rsp_valid
);
    logic rd_out_q;
    logic owner_mem_q;

    // Port mux and grant generation.
    always_comb begin
        int_req_valid = !rd_out_q && (s_valid || m_valid);
        int_req_write = s_valid ? s_write : m_write;
        int_req_mem   = !s_valid;
        int_req_addr  = s_valid ? s_addr  : m_addr;
        int_req_wdata = s_valid ? s_wdata : m_wdata;
        s_grant       = !rd_out_q && s_valid && int_req_ready;
        m_grant       = !rd_out_q && !s_valid && m_valid && int_req_ready;
        s_rsp         = int_rsp_valid && rd_out_q && !owner_mem_q;
        m_rsp         = int_rsp_valid && rd_out_q && owner_mem_q;
    end

    // Outstanding-read tracker and its owner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_out_q    <= 1'b0;
            owner_mem_q <= 1'b0;
        end else if (rd_out_q && int_rsp_valid) begin
            rd_out_q <= 1'b0;
        end else if (int_req_valid && int_req_ready && !int_req_write) begin
            rd_out_q    <= 1'b1;
            owner_mem_q <= int_req_mem;
        end
    end

    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req_valid && !int_req_ready) |=>
        (int_req_valid && $stable(int_req_write) && $stable(int_req_addr)
         && $stable(int_req_wdata) && $stable(int_req_mem)));

    a_r9_read_origin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_out_q) |-> $past(int_req_valid && int_req_ready && !int_req_write));

    a_r9_single_route: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({s_rsp, m_rsp, s_grant, m_grant}));
endmodule

// File: rtl/indirect_reg_window.sv
// Top of the indirect register access window: decodes the host register
// port, instantiates the shared-register engine, the memory window and the
// port arbiter, and builds the combinational host read mux.
// Assumes host_rdata is sampled in the cycle host_rd_en is high.
module indirect_reg_window
    import irw_pkg::*;
#(
    parameter int DW   = 32,
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_wr_en,
    input  logic            host_rd_en,
    input  logic [HA_W-1:0] host_addr,
    input  logic [DW-1:0]   host_wdata,
    output logic [DW-1:0]   host_rdata,
    output logic            host_busy,
    output logic            int_req_valid,
    input  logic            int_req_ready,
    output logic            int_req_write,
    output logic            int_req_mem,
    output logic [AW-1:0]   int_req_addr,
    output logic [DW-1:0]   int_req_wdata,
    input  logic            int_rsp_valid,
    input  logic [DW-1:0]   int_rsp_data
);
    logic sel_ctrl, sel_data, sel_raddr, sel_waddr, sel_wdat, sel_rdat;

    logic [DW-1:0] s_ctrl_word, s_data_word, m_rdat;
    logic [AW-1:0] m_raddr, m_waddr;
    logic          s_valid, s_write, s_grant, s_rsp, s_busy;
    logic [AW-1:0] s_addr;
    logic [DW-1:0] s_wdata;
    logic          m_valid, m_write, m_grant, m_rsp, m_busy;
    logic [AW-1:0] m_addr;
    logic [DW-1:0] m_wdata;

    // Host offset decode.
    always_comb begin
        sel_ctrl  = host_addr == OFS_SHR_CTRL;
        sel_data  = host_addr == OFS_SHR_DATA;
        sel_raddr = host_addr == OFS_MEM_RADDR;
        sel_waddr = host_addr == OFS_MEM_WADDR;
        sel_wdat  = host_addr == OFS_MEM_WDAT;
        sel_rdat  = host_addr == OFS_MEM_RDAT;
    end

    irw_shr_engine #(.DW(DW), .AW(AW)) u_shr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_we   (host_wr_en && sel_ctrl),
        .data_we   (host_wr_en && sel_data),
        .op_in     (host_wdata[OP_LSB +: 2]),
        .off_in    (host_wdata[OFF_W-1:0]),
        .wdata_in  (host_wdata),
        .ctrl_word (s_ctrl_word),
        .data_word (s_data_word),
        .req_valid (s_valid),
        .req_write (s_write),
        .req_addr  (s_addr),
        .req_wdata (s_wdata),
        .grant     (s_grant),
        .rsp_valid (s_rsp),
        .rsp_data  (int_rsp_data),
        .busy      (s_busy)
    );

    irw_mem_engine #(.DW(DW), .AW(AW), .STEP(STEP)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .raddr_we  (host_wr_en && sel_raddr),
        .waddr_we  (host_wr_en && sel_waddr),
        .wdat_we   (host_wr_en && sel_wdat),
        .rdat_re   (host_rd_en && sel_rdat),
        .wdata_in  (host_wdata),
        .raddr_out (m_raddr),
        .waddr_out (m_waddr),
        .rdat_out  (m_rdat),
        .req_valid (m_valid),
        .req_write (m_write),
        .req_addr  (m_addr),
        .req_wdata (m_wdata),
        .grant     (m_grant),
        .rsp_valid (m_rsp),
        .rsp_data  (int_rsp_data),
        .busy      (m_busy)
    );

    irw_port_arb #(.DW(DW), .AW(AW)) u_arb (
        .clk           (clk),
        .rst_n         (rst_n),
        .s_valid       (s_valid),
        .s_write       (s_write),
        .s_addr        (s_addr),
        .s_wdata       (s_wdata),
        .m_valid       (m_valid),
        .m_write       (m_write),
        .m_addr        (m_addr),
        .m_wdata       (m_wdata),
        .s_grant       (s_grant),
        .m_grant       (m_grant),
        .s_rsp         (s_rsp),
        .m_rsp         (m_rsp),
        .int_req_valid (int_req_valid),
        .int_req_ready (int_req_ready),
        .int_req_write (int_req_write),
        .int_req_mem   (int_req_mem),
        .int_req_addr  (int_req_addr),
        .int_req_wdata (int_req_wdata),
        .int_rsp_valid (int_rsp_valid)
    );

    // Host read mux and busy merge.
    always_comb begin
        host_busy = s_busy | m_busy;
        unique case (1'b1)
            sel_ctrl:  host_rdata = s_ctrl_word;
            sel_data:  host_rdata = s_data_word;
            sel_raddr: host_rdata = DW'(m_raddr);
            sel_waddr: host_rdata = DW'(m_waddr);
            sel_rdat:  host_rdata = m_rdat;
            default:   host_rdata = '0;
        endcase
    end

    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !host_busy |-> !int_req_valid);
endmodule

// File: tb/indirect_reg_window_bench.sv
// Bench: behavioural target storage and expected-request queue, per-clock
// comparison of busy and port protocol, transaction-level data checks.
module indirect_reg_window_bench;
    import irw_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst_n = 1'b0;
    logic            host_wr_en = 1'b0, host_rd_en = 1'b0;
    logic [HA_W-1:0] host_addr = '0;
    logic [31:0]     host_wdata = '0, host_rdata;
    logic            host_busy;
    logic            int_req_valid, int_req_write, int_req_mem;
    logic            int_req_ready = 1'b0;
    logic [31:0]     int_req_addr, int_req_wdata;
    logic            int_rsp_valid = 1'b0;
    logic [31:0]     int_rsp_data = '0;

    indirect_reg_window u_indirect_reg_window (
        .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_busy(host_busy), .int_req_valid(int_req_valid), .int_req_ready(int_req_ready),
        .int_req_write(int_req_write), .int_req_mem(int_req_mem), .int_req_addr(int_req_addr),
        .int_req_wdata(int_req_wdata), .int_rsp_valid(int_rsp_valid), .int_rsp_data(int_rsp_data)
    );

    int errors = 0;
    int checks = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    typedef struct {
        bit          wr;
        bit          mem;
        logic [31:0] a;
        logic [31:0] d;
        string       tag;
    } exp_req_t;
    exp_req_t exq[$];

    logic [31:0] reg_store [logic [31:0]];
    logic [31:0] mem_store [logic [31:0]];
    logic [31:0] ref_reg   [logic [31:0]];
    logic [31:0] ref_mem   [logic [31:0]];

    function automatic logic [31:0] init_mem(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction
    function automatic logic [31:0] init_reg(input logic [31:0] a);
        return 32'hC0DE0000 | {16'h0, a[15:0]};
    endfunction
    function automatic logic [31:0] ref_mem_at(input logic [31:0] a);
        return ref_mem.exists(a) ? ref_mem[a] : init_mem(a);
    endfunction
    function automatic logic [31:0] ref_reg_at(input logic [31:0] a);
        return ref_reg.exists(a) ? ref_reg[a] : init_reg(a);
    endfunction

    // Responder and per-clock reference state.
    int          cyc = 0;
    int          rsp_cnt = -1;
    logic [31:0] rsp_hold = '0;
    bit          exp_busy = 0, drop_pend = 0, read_out = 0, prev_wait = 0;
    logic [31:0] prev_addr = '0, prev_wdata = '0;
    bit          prev_write = 0, prev_mem = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (drop_pend) begin
                exp_busy  = 0;
                drop_pend = 0;
            end
            chk(host_busy === exp_busy, "R2 busy tracking", {31'b0, host_busy}, {31'b0, exp_busy});
            if (read_out)
                chk(!int_req_valid, "R9 request while read outstanding", {31'b0, int_req_valid}, 32'd0);
            if (prev_wait)
                chk(int_req_valid && int_req_addr == prev_addr && int_req_wdata == prev_wdata
                    && int_req_write == prev_write && int_req_mem == prev_mem,
                    "R8 request held under back-pressure", int_req_addr, prev_addr);
            int_rsp_valid = 1'b0;
            if (rsp_cnt > 0) begin
                rsp_cnt--;
                if (rsp_cnt == 0) begin
                    int_rsp_valid = 1'b1;
                    int_rsp_data  = rsp_hold;
                    drop_pend     = 1;
                    read_out      = 0;
                    rsp_cnt       = -1;
                end
            end
            int_req_ready = (cyc % 3) != 1;
            if (int_req_valid && int_req_ready) begin
                if (exq.size() == 0) begin
                    chk(0, "R4 unexpected request", int_req_addr, 32'hFFFFFFFF);
                end else begin
                    exp_req_t e;
                    e = exq.pop_front();
                    chk(int_req_write == e.wr && int_req_mem == e.mem && int_req_addr == e.a,
                        {e.tag, " request kind/address"}, int_req_addr, e.a);
                    if (e.wr)
                        chk(int_req_wdata == e.d, {e.tag, " request data"}, int_req_wdata, e.d);
                end
                if (int_req_write) begin
                    if (int_req_mem) mem_store[int_req_addr] = int_req_wdata;
                    else             reg_store[int_req_addr] = int_req_wdata;
                    drop_pend = 1;
                end else begin
                    read_out = 1;
                    rsp_cnt  = 1 + (cyc % 3);
                    if (int_req_mem)
                        rsp_hold = mem_store.exists(int_req_addr) ? mem_store[int_req_addr] : init_mem(int_req_addr);
                    else
                        rsp_hold = reg_store.exists(int_req_addr) ? reg_store[int_req_addr] : init_reg(int_req_addr);
                end
            end
            prev_wait  = int_req_valid && !int_req_ready;
            prev_addr  = int_req_addr;
            prev_wdata = int_req_wdata;
            prev_write = int_req_write;
            prev_mem   = int_req_mem;
        end
    end

    task automatic hw(input logic [HA_W-1:0] a, input logic [31:0] d, input bit launches);
        @(negedge clk);
        host_addr  = a;
        host_wdata = d;
        host_wr_en = 1'b1;
        @(posedge clk);
        #1 host_wr_en = 1'b0;
        if (launches) exp_busy = 1;
    endtask

    task automatic hr(input logic [HA_W-1:0] a, output logic [31:0] d, input bit launches);
        @(negedge clk);
        host_addr  = a;
        host_rd_en = 1'b1;
        #1 d = host_rdata;
        @(posedge clk);
        #1 host_rd_en = 1'b0;
        if (launches) exp_busy = 1;
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 50; n++) begin
            @(negedge clk);
            #2;
            if (!host_busy) break;
        end
    endtask

    task automatic push(input bit wr, input bit mem, input logic [31:0] a, input logic [31:0] d, input string tag);
        exp_req_t e;
        e.wr = wr; e.mem = mem; e.a = a; e.d = d; e.tag = tag;
        exq.push_back(e);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [31:0] ptr;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!host_busy && !int_req_valid, "R1 busy/valid after reset", {30'b0, host_busy, int_req_valid}, 32'd0);
        hr(OFS_SHR_CTRL, d, 0);  chk(d == 32'd0, "R1 control reset", d, 32'd0);
        hr(OFS_SHR_DATA, d, 0);  chk(d == 32'd0, "R1 data reset", d, 32'd0);
        hr(OFS_MEM_RADDR, d, 0); chk(d == 32'd0, "R1 read pointer reset", d, 32'd0);
        hr(OFS_MEM_WADDR, d, 0); chk(d == 32'd0, "R1 write pointer reset", d, 32'd0);
        push(0, 1, 32'd4, 32'd0, "R6");
        hr(OFS_MEM_RDAT, d, 1);  chk(d == 32'd0, "R1 read data reset", d, 32'd0);
        wait_idle();

        // R4 and R10: no-op codes, control readback
        hw(OFS_SHR_CTRL, 32'h9A5A5678, 0);
        repeat (4) @(negedge clk);
        hr(OFS_SHR_CTRL, d, 0);  chk(d == 32'h10005678, "R10 readback op 1", d, 32'h10005678);
        hw(OFS_SHR_CTRL, 32'hCDEF1234, 0);
        repeat (4) @(negedge clk);
        hr(OFS_SHR_CTRL, d, 0);  chk(d == 32'h00001234, "R10 readback op 0", d, 32'h00001234);
        chk(exq.size() == 0, "R4 no request for no-op codes", exq.size(), 32'd0);

        // R3: shared writes with preloaded data
        hw(OFS_SHR_DATA, 32'h11223344, 0);
        ref_reg[32'h120] = 32'h11223344;
        push(1, 0, 32'h120, 32'h11223344, "R3");
        hw(OFS_SHR_CTRL, 32'hF0000120, 1);
        wait_idle();
        chk(reg_store.exists(32'h120) && reg_store[32'h120] == 32'h11223344, "R3 target updated",
            reg_store.exists(32'h120) ? reg_store[32'h120] : 32'hX, 32'h11223344);
        hw(OFS_SHR_DATA, 32'hA5A55A5A, 0);
        ref_reg[32'hFFFC] = 32'hA5A55A5A;
        push(1, 0, 32'hFFFC, 32'hA5A55A5A, "R3");
        hw(OFS_SHR_CTRL, 32'h3000FFFC, 1);
        wait_idle();

        // R2: shared reads
        push(0, 0, 32'h120, 32'd0, "R2");
        hw(OFS_SHR_CTRL, 32'h20000120, 1);
        wait_idle();
        hr(OFS_SHR_DATA, d, 0);  chk(d == ref_reg_at(32'h120), "R2 read of written register", d, ref_reg_at(32'h120));
        push(0, 0, 32'h0BCD, 32'd0, "R2");
        hw(OFS_SHR_CTRL, 32'h20000BCD, 1);
        wait_idle();
        hr(OFS_SHR_DATA, d, 0);  chk(d == ref_reg_at(32'h0BCD), "R2 read of untouched register", d, ref_reg_at(32'h0BCD));
        hr(OFS_SHR_CTRL, d, 0);  chk(d == 32'h20000BCD, "R10 readback op 2", d, 32'h20000BCD);

        // R5 and R6: read stream
        push(0, 1, 32'h100, 32'd0, "R5");
        hw(OFS_MEM_RADDR, 32'h100, 1);
        wait_idle();
        hr(OFS_MEM_RADDR, d, 0); chk(d == 32'h100, "R5 read pointer readback", d, 32'h100);
        ptr = 32'h100;
        for (int i = 0; i < 6; i++) begin
            push(0, 1, ptr + 32'd4, 32'd0, "R6");
            hr(OFS_MEM_RDAT, d, 1);
            chk(d == ref_mem_at(ptr), "R6 streamed read word", d, ref_mem_at(ptr));
            ptr = ptr + 32'd4;
            wait_idle();
        end
        hr(OFS_MEM_RADDR, d, 0); chk(d == ptr, "R6 read pointer advanced", d, ptr);

        // R7: write stream
        hw(OFS_MEM_WADDR, 32'h104, 0);
        ref_mem[32'h104] = 32'hDEADBEEF;
        push(1, 1, 32'h104, 32'hDEADBEEF, "R7");
        hw(OFS_MEM_WDAT, 32'hDEADBEEF, 1);
        wait_idle();
        ref_mem[32'h108] = 32'h0BADF00D;
        push(1, 1, 32'h108, 32'h0BADF00D, "R7");
        hw(OFS_MEM_WDAT, 32'h0BADF00D, 1);
        wait_idle();
        hr(OFS_MEM_WADDR, d, 0); chk(d == 32'h10C, "R7 write pointer advanced", d, 32'h10C);

        // R5/R6 readback of the written words
        push(0, 1, 32'h100, 32'd0, "R5");
        hw(OFS_MEM_RADDR, 32'h100, 1);
        wait_idle();
        ptr = 32'h100;
        for (int i = 0; i < 3; i++) begin
            push(0, 1, ptr + 32'd4, 32'd0, "R6");
            hr(OFS_MEM_RDAT, d, 1);
            chk(d == ref_mem_at(ptr), "R7 written word read back", d, ref_mem_at(ptr));
            ptr = ptr + 32'd4;
            wait_idle();
        end

        repeat (5) @(negedge clk);
        chk(exq.size() == 0, "R9 all expected requests issued", exq.size(), 32'd0);
        finish_run();
    end
endmodule